// File: doc/BRIEF.md
# Boot-State and Warm-Reset Control Register

This block is a single privileged 32-bit control word. It holds two live bits: a boot-state bit that picks whether the processor comes out of its next warm reset in the 32-bit or the 64-bit execution state, and a request bit through which software asks for a warm reset. Every other bit of the word is reserved. Software reaches the word through a simple access port: enable, write strobe, address, write data and registered read data. A privilege-level input and a security-state input gate each access.

The two resets treat the word differently. A cold reset loads the boot-state bit from a strap pin and clears the request bit. A warm reset clears only the request bit, so a boot state programmed before it takes effect afterwards. The block drives the chosen execution state and a reset vector to the core. The reset vector is always one of two hardwired addresses, picked by the boot-state bit. A write that newly sets the request bit produces a one-cycle request pulse for an external reset controller. The block does not act on the request itself.

Top module: `boot_state_ctrl`

## Requirements
- R1: Bits 31:2 of the word are reserved. They always read as zero, and writing ones to them has no effect on anything the block drives.
- R2: While `cold_rst_n` is low, the request bit is 0 and the boot-state bit follows `strap_boot64`. `warm_req`, `acc_fault` and `acc_rdata` are 0 during cold reset.
- R3: A cycle with `warm_rst` high clears the request bit and leaves the boot-state bit unchanged. Any access presented in that cycle is ignored. The pulse, fault and read-data outputs are 0 in the following cycle.
- R4: When `cold_rst_n` is low and `warm_rst` is high together, the cold-reset behaviour of R2 applies. In particular, the boot-state bit takes the strap value.
- R5: A permitted write loads the request bit from write-data bit 1 and the boot-state bit from write-data bit 0. A permitted read returns `{30'b0, request, boot_state}` on `acc_rdata` in the cycle after the access. `acc_rdata` is 0 in every other cycle.
- R6: An access that matches the address at a privilege level below 3 changes nothing. It returns zero read data and asserts `acc_fault` for exactly the next cycle.
- R7: At privilege level 3, accesses are permitted whether `secure` is 0 or 1.
- R8: `warm_req` pulses high for one cycle, in the cycle after a permitted write takes the request bit from 0 to 1. It is not raised again while the request bit stays 1, even if 1 is written again.
- R9: `rst_vec` equals `VEC_BOOT64` when the boot-state bit is 1 and `VEC_BOOT32` when it is 0. It never takes any other value.
- R10: `boot64` is the current value of the boot-state bit (1 = 64-bit state, 0 = 32-bit state).
- R11: An access whose address does not equal `REG_ADDR` is ignored. It changes nothing, raises no fault and returns zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous active-low cold reset |
| warm_rst | input | 1 | Synchronous active-high warm reset |
| strap_boot64 | input | 1 | Boot-state value loaded on cold reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Access address |
| acc_wdata | input | 32 | Write data |
| priv_lvl | input | 2 | Privilege level of the access (3 = highest) |
| secure | input | 1 | Security state of the access |
| acc_rdata | output | 32 | Registered read data |
| acc_fault | output | 1 | One-cycle denied-access flag |
| warm_req | output | 1 | One-cycle warm-reset request pulse |
| boot64 | output | 1 | Selected boot execution state |
| rst_vec | output | VEC_W | Reset vector address |

## Verification
The hardest case to reach from the ports is a boot-state bit that differs from the strap at the moment a warm reset lands, since a cold reset always re-aligns the two. The stimulus first programs the opposite value through a permitted write, then applies the warm reset, and then reads the word back. It also holds cold reset and warm reset together after such a write, so that the strap value must win. A second write of 1 to the request bit while it is already set checks that no second pulse appears.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int REG_W = 32;
  typedef logic [1:0] priv_t;
  localparam priv_t PRIV_TOP = 2'd3;

  function automatic logic access_allowed(input priv_t lvl, input logic sec, input logic allow_ns);
    return (lvl == PRIV_TOP) && (sec || allow_ns);
  endfunction

  function automatic logic [REG_W-1:0] pack_view(input logic req_bit, input logic boot_bit);
    return {{(REG_W-2){1'b0}}, req_bit, boot_bit};
  endfunction

  function automatic logic rising_request(input logic old_bit, input logic new_bit);
    return new_bit && !old_bit;
  endfunction
endpackage

// File: rtl/bsc_access_decode.sv
module bsc_access_decode #(
  parameter int          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter bit          ALLOW_NS = 1'b1
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_rst,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  bsc_pkg::priv_t    priv_lvl,
  input  logic              secure,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic              deny_evt
);
  import bsc_pkg::*;

  logic hit, grant;

  always_comb begin
    hit      = acc_en && (acc_addr == REG_ADDR) && !warm_rst;
    grant    = access_allowed(priv_lvl, secure, ALLOW_NS);
    wr_ok    = hit && grant && acc_wr;
    rd_ok    = hit && grant && !acc_wr;
    deny_evt = hit && !grant;
  end

  // R6: nothing below the top level is ever granted
  p_low_priv_denied_r6: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (priv_lvl != PRIV_TOP) |-> !(wr_ok || rd_ok));
  // R11: a wrong address produces no event of any kind
  p_addr_miss_quiet_r11: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (acc_addr != REG_ADDR) |-> !(wr_ok || rd_ok || deny_evt));
endmodule

// File: rtl/bsc_state_regs.sv
module bsc_state_regs (
  input  logic                      clk,
  input  logic                      cold_rst_n,
  input  logic                      warm_rst,
  input  logic                      strap_boot64,
  input  logic                      wr_ok,
  input  logic                      rd_ok,
  input  logic                      deny_evt,
  input  logic [bsc_pkg::REG_W-1:0] wdata,
  output logic                      req_q,
  output logic                      boot_q,
  output logic                      warm_req,
  output logic                      acc_fault,
  output logic [bsc_pkg::REG_W-1:0] rdata
);
  import bsc_pkg::*;

  logic set_evt;
  assign set_evt = wr_ok && rising_request(req_q, wdata[1]);

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      req_q     <= 1'b0;
      boot_q    <= strap_boot64;
      warm_req  <= 1'b0;
      acc_fault <= 1'b0;
      rdata     <= '0;
    end else if (warm_rst) begin
      req_q     <= 1'b0;
      warm_req  <= 1'b0;
      acc_fault <= 1'b0;
      rdata     <= '0;
    end else begin
      warm_req  <= set_evt;
      acc_fault <= deny_evt;
      rdata     <= rd_ok ? pack_view(req_q, boot_q) : '0;
      if (wr_ok) begin
        req_q  <= wdata[1];
        boot_q <= wdata[0];
      end
    end
  end

  // R1: reserved bits never read back as anything but zero
  p_resv_zero_r1: assert property (@(posedge clk) disable iff (!cold_rst_n)
    rdata[REG_W-1:2] == '0);
  // R1: a write leaves only its two low bits in the word
  p_resv_ignored_r1: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (wr_ok && !warm_rst) |=> ({req_q, boot_q} == $past(wdata[1:0])));
  // R3: warm reset keeps the boot bit and drops the request
  p_warm_keeps_boot_r3: assert property (@(posedge clk) disable iff (!cold_rst_n)
    warm_rst |=> (boot_q == $past(boot_q)) && !req_q && !warm_req);
  // R6: a denied access leaves state alone and flags a fault
  p_deny_hold_r6: assert property (@(posedge clk) disable iff (!cold_rst_n)
    deny_evt |=> $stable(boot_q) && $stable(req_q) && acc_fault && (rdata == '0));
  // R8: request pulse lasts one cycle
  p_req_single_r8: assert property (@(posedge clk) disable iff (!cold_rst_n)
    warm_req |=> !warm_req);
  // R8: a pulse only accompanies a set request bit
  p_req_bit_set_r8: assert property (@(posedge clk) disable iff (!cold_rst_n)
    warm_req |-> req_q);
endmodule

// File: rtl/bsc_vector_sel.sv
module bsc_vector_sel #(
  parameter int               VEC_W      = 32,
  parameter logic [VEC_W-1:0] VEC_BOOT32 = '0,
  parameter logic [VEC_W-1:0] VEC_BOOT64 = '1
) (
  input  logic             clk,
  input  logic             cold_rst_n,
  input  logic             boot_q,
  output logic [VEC_W-1:0] rst_vec
);
  function automatic logic [VEC_W-1:0] pick_vector(input logic sel);
    return sel ? VEC_BOOT64 : VEC_BOOT32;
  endfunction

  assign rst_vec = pick_vector(boot_q);

  // R9: the vector is one of the two hardwired addresses
  p_vec_pair_r9: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (rst_vec == VEC_BOOT32) || (rst_vec == VEC_BOOT64));
endmodule

// File: rtl/boot_state_ctrl.sv
module boot_state_ctrl #(
  parameter int               ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h3C,
  parameter bit               ALLOW_NS   = 1'b1,
  parameter int               VEC_W      = 32,
  parameter logic [VEC_W-1:0] VEC_BOOT32 = 32'hFFFF_0000,
  parameter logic [VEC_W-1:0] VEC_BOOT64 = 32'h4000_0000
) (
  input  logic                      clk,
  input  logic                      cold_rst_n,
  input  logic                      warm_rst,
  input  logic                      strap_boot64,
  input  logic                      acc_en,
  input  logic                      acc_wr,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic [bsc_pkg::REG_W-1:0] acc_wdata,
  input  logic [1:0]                priv_lvl,
  input  logic                      secure,
  output logic [bsc_pkg::REG_W-1:0] acc_rdata,
  output logic                      acc_fault,
  output logic                      warm_req,
  output logic                      boot64,
  output logic [VEC_W-1:0]          rst_vec
);
  logic wr_ok, rd_ok, deny_evt;
  logic req_q, boot_q;

  bsc_access_decode #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .ALLOW_NS(ALLOW_NS)
  ) u_decode (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst(warm_rst),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .priv_lvl(priv_lvl), .secure(secure),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .deny_evt(deny_evt)
  );

  bsc_state_regs u_state (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst(warm_rst),
    .strap_boot64(strap_boot64), .wr_ok(wr_ok), .rd_ok(rd_ok),
    .deny_evt(deny_evt), .wdata(acc_wdata),
    .req_q(req_q), .boot_q(boot_q), .warm_req(warm_req),
    .acc_fault(acc_fault), .rdata(acc_rdata)
  );

  bsc_vector_sel #(
    .VEC_W(VEC_W), .VEC_BOOT32(VEC_BOOT32), .VEC_BOOT64(VEC_BOOT64)
  ) u_vec (
    .clk(clk), .cold_rst_n(cold_rst_n), .boot_q(boot_q), .rst_vec(rst_vec)
  );

  assign boot64 = boot_q;

  // R10: the state output only moves on a write or a cold reset
  p_boot_moves_on_write_r10: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (!wr_ok) |=> $stable(boot64));
  // R8: the request pulse never appears without the bit set
  p_req_implies_bit_r8: assert property (@(posedge clk) disable iff (!cold_rst_n)
    warm_req |-> req_q);
endmodule

// File: tb/boot_state_ctrl_tb.sv
`timescale 1ns/1ps
module boot_state_ctrl_tb;
  localparam logic [7:0]  ADDR = 8'h3C;
  localparam logic [31:0] V32  = 32'hFFFF_0000;
  localparam logic [31:0] V64  = 32'h4000_0000;

  logic clk = 1'b0;
  logic cold_rst_n, warm_rst, strap_boot64, acc_en, acc_wr, secure;
  logic [7:0]  acc_addr;
  logic [31:0] acc_wdata, acc_rdata, rst_vec;
  logic [1:0]  priv_lvl;
  logic acc_fault, warm_req, boot64;

  always #4 clk = ~clk;

  boot_state_ctrl u_dut (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst(warm_rst),
    .strap_boot64(strap_boot64), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .priv_lvl(priv_lvl),
    .secure(secure), .acc_rdata(acc_rdata), .acc_fault(acc_fault),
    .warm_req(warm_req), .boot64(boot64), .rst_vec(rst_vec)
  );

  typedef struct {
    int          due;
    logic [31:0] rdata;
    logic        fault;
    logic        req;
    logic        boot;
    logic [31:0] vec;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  logic m_req, m_boot;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop and compare items that fall due this cycle
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (acc_rdata !== e.rdata || acc_fault !== e.fault || warm_req !== e.req ||
          boot64 !== e.boot || rst_vec !== e.vec) begin
        n_bad++;
        $display("FAIL %s: got rdata=%h fault=%b req=%b boot=%b vec=%h exp rdata=%h fault=%b req=%b boot=%b vec=%h",
                 e.tag, acc_rdata, acc_fault, warm_req, boot64, rst_vec,
                 e.rdata, e.fault, e.req, e.boot, e.vec);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: got %h exp %h", tag, act, expv);
    end
  endtask

  // driver: present one cycle of stimulus and queue what must follow it
  task automatic step(input logic en, input logic wr, input logic [7:0] addr,
                      input logic [31:0] wd, input logic [1:0] pr, input logic sec,
                      input logic wm, input string tag);
    exp_t e;
    logic hit, ok;
    @(negedge clk);
    acc_en = en; acc_wr = wr; acc_addr = addr; acc_wdata = wd;
    priv_lvl = pr; secure = sec; warm_rst = wm;
    e.tag = tag; e.due = cyc + 1;
    e.rdata = '0; e.fault = 1'b0; e.req = 1'b0;
    if (wm) begin
      m_req = 1'b0;
    end else begin
      hit = en && (addr == ADDR);
      ok  = hit && (pr == 2'd3);
      e.fault = hit && !ok;
      if (ok && !wr) e.rdata = {30'b0, m_req, m_boot};
      if (ok && wr) begin
        e.req  = wd[1] && !m_req;
        m_req  = wd[1];
        m_boot = wd[0];
      end
    end
    e.boot = m_boot;
    e.vec  = m_boot ? V64 : V32;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 8'h00, 32'h0, 2'd0, 1'b0, 1'b0, tag);
  endtask

  task automatic cold(input logic strap_v, input logic warm_too, input string tag);
    @(negedge clk);
    exp_q.delete();
    acc_en = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_wdata = '0;
    priv_lvl = 2'd0; secure = 1'b0;
    strap_boot64 = strap_v; warm_rst = warm_too; cold_rst_n = 1'b0;
    #1;
    chk(tag, {28'b0, boot64, warm_req, acc_fault, 1'b0}, {28'b0, strap_v, 3'b000});
    chk(tag, acc_rdata, 32'h0);
    chk(tag, rst_vec, strap_v ? V64 : V32);
    @(negedge clk);
    cold_rst_n = 1'b1; warm_rst = 1'b0;
    m_req = 1'b0; m_boot = strap_v;
  endtask

  initial begin
    warm_rst = 1'b0; strap_boot64 = 1'b0; cold_rst_n = 1'b0;
    acc_en = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_wdata = '0;
    priv_lvl = 2'd0; secure = 1'b0;
    m_req = 1'b0; m_boot = 1'b0;

    cold(1'b0, 1'b0, "R2 cold strap0");
    step(1, 0, ADDR, 0, 3, 0, 0, "R5 read after cold");
    step(1, 1, ADDR, 32'h1, 3, 0, 0, "R7 R10 write boot64 nonsecure");
    step(1, 0, ADDR, 0, 3, 0, 0, "R9 read boot64");
    step(1, 1, ADDR, 32'hFFFF_FFFF, 3, 1, 0, "R1 R8 write ones secure");
    idle("R8 pulse ends");
    step(1, 0, ADDR, 0, 3, 1, 0, "R1 read reserved zero");
    step(1, 1, ADDR, 32'h3, 3, 0, 0, "R8 rewrite no pulse");
    step(1, 1, ADDR, 32'h0, 2, 1, 0, "R6 denied write");
    step(1, 0, ADDR, 0, 1, 0, 0, "R6 denied read");
    step(1, 0, ADDR, 0, 3, 0, 0, "R6 state kept");
    step(1, 1, 8'h3D, 32'h0, 3, 0, 0, "R11 wrong addr write");
    step(1, 0, 8'h10, 0, 3, 0, 0, "R11 wrong addr read");
    step(1, 0, ADDR, 0, 3, 0, 0, "R11 state kept");
    step(1, 1, ADDR, 32'h0, 3, 0, 1, "R3 warm with write ignored");
    step(1, 0, ADDR, 0, 3, 0, 0, "R3 boot kept req cleared");
    step(1, 1, ADDR, 32'h0, 3, 0, 0, "R10 write boot32");
    step(0, 0, 8'h0, 0, 0, 0, 1, "R3 warm keeps boot32");
    step(1, 0, ADDR, 0, 3, 1, 0, "R9 vector boot32");
    step(1, 1, ADDR, 32'h2, 3, 1, 0, "R8 request pulse again");
    step(1, 0, ADDR, 0, 3, 0, 0, "R5 read request");
    idle("R8 idle");
    cold(1'b1, 1'b0, "R2 cold strap1");
    step(1, 0, ADDR, 0, 3, 0, 0, "R2 read after strap1");
    step(1, 1, ADDR, 32'h2, 3, 0, 0, "R5 write boot32 with request");
    cold(1'b1, 1'b1, "R4 cold over warm");
    step(1, 0, ADDR, 0, 3, 0, 0, "R4 read after both resets");
    idle("R4 idle");
    idle("R4 idle");
    @(negedge clk);
    @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d items left, exp 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule